// File: doc/BRIEF.md
# Exception Handler Address Generator

This block works out the address where instruction fetch resumes when the core acknowledges a reset, a synchronous exception, an FE-level or EI-level exception, or a user interrupt. The acknowledge logic presents an event code together with the interrupt priority and channel and the mode flag as it stands after the status update. It also presents two vector base registers, each carrying a reduced-offset flag in bit 0, a table base register and a per-channel flag that selects table lookup.

For direct vectoring the block adds a fixed, event-dependent offset to the chosen base and returns the result one cycle later. For a user interrupt whose channel selects table lookup, it issues a word read to a lookup table through a request/valid port. It waits for the reply and returns the fetched pointer with bit 0 cleared. A `busy` output covers the wait, and new acknowledges are dropped during that time.

Top module: `heg_vector_gen`

## Requirements
- R1: After a synchronous reset, `done`, `busy` and `rd_req` are all 0.
- R2: Event code 0 (reset) always yields `reset_base` with bits 8:0 cleared plus offset 0x000, whatever `ebv` is, and never issues a table read, even when the channel's table-select flag is set.
- R3: For every other event code, the base is `exc_base` when `ebv` is 1 and `reset_base` when `ebv` is 0. Bits 8:0 of the chosen base never reach the address.
- R4: Exception offsets are 0x010 for code 1 (synchronous), 0x030 for code 2 (FE-level) and 0x040 for code 3 (EI-level). Codes 5 to 7 behave as code 1.
- R5: A direct user interrupt (code 4) whose selected base has bit 0 clear uses offset 0x100 + priority × 0x10, with a 4-bit priority.
- R6: When bit 0 of the selected base is set, every direct user interrupt uses offset 0x100 whatever its priority. The flag of the other base register has no effect.
- R7: A direct result appears on `handler_addr` with `done` high for exactly one cycle, in the cycle after the one where `ack_valid` was sampled. Back-to-back acknowledges give back-to-back results.
- R8: A user interrupt on a channel whose `table_sel` bit is 1 raises `rd_req` and `busy` in the next cycle. `rd_addr` = `table_base` + channel × 4 is held steady until `rd_valid` is seen.
- R9: In the cycle after `rd_valid` is sampled with a read outstanding, `done` pulses with `rd_data` having bit 0 cleared, and `busy` and `rd_req` drop in that same cycle.
- R10: An acknowledge that arrives while `busy` is high is dropped, and `rd_valid` while idle is ignored. Neither produces a `done` pulse or alters `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_kind | input | 3 | Event code: 0 reset, 1 sync, 2 FE, 3 EI, 4 user interrupt |
| ack_prio | input | 4 | User interrupt priority |
| ack_chan | input | CH_W (5) | User interrupt channel |
| ebv | input | 1 | Base select flag after status update |
| reset_base | input | AW (32) | Reset vector base, bit 0 = reduced-offset flag |
| exc_base | input | AW (32) | Exception vector base, bit 0 = reduced-offset flag |
| table_base | input | AW (32) | Handler table base address |
| table_sel | input | NUM_CH (32) | Per-channel table-lookup select |
| rd_req | output | 1 | Table read request, held until reply |
| rd_addr | output | AW (32) | Table read address |
| rd_valid | input | 1 | Table read reply valid |
| rd_data | input | AW (32) | Table read data |
| handler_addr | output | AW (32) | Computed handler address |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Table read outstanding |

## Verification
A direct result is due exactly one clock after the acknowledge is sampled. A table result is due one clock after the read reply is sampled, however many cycles the reply took. The driver stamps each expected address with the cycle in which it is due. The monitor samples on the falling edge and compares both the address and the cycle of every `done`, so a result that is early, late or unasked-for is caught. Request, address and busy levels are read on the falling edge after each stimulus, and dropped acknowledges are confirmed by the absence of any pulse.

// File: rtl/heg_pkg.sv
package heg_pkg;
  typedef enum logic [2:0] {
    EV_RESET = 3'd0,
    EV_SYNC  = 3'd1,
    EV_FE    = 3'd2,
    EV_EI    = 3'd3,
    EV_UINT  = 3'd4
  } ev_kind_e;

  localparam int unsigned OFS_RESET = 'h000;
  localparam int unsigned OFS_SYNC  = 'h010;
  localparam int unsigned OFS_FE    = 'h030;
  localparam int unsigned OFS_EI    = 'h040;
  localparam int unsigned OFS_UINT  = 'h100;
endpackage

// File: rtl/heg_direct.sv
module heg_direct
  import heg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PRIO_W = 4,
  parameter int ALIGN  = 9
) (
  input  logic [2:0]        kind,
  input  logic [PRIO_W-1:0] prio,
  input  logic              ebv,
  input  logic [AW-1:0]     rst_base,
  input  logic [AW-1:0]     exc_base,
  output logic [AW-1:0]     addr
);
  logic [AW-1:0]    base_sel;
  logic [ALIGN-1:0] offset;
  logic             rint;

  always_comb begin
    if (kind == EV_RESET || !ebv) base_sel = rst_base;
    else                          base_sel = exc_base;
    rint = base_sel[0];
    case (kind)
      EV_RESET: offset = ALIGN'(OFS_RESET);
      EV_FE:    offset = ALIGN'(OFS_FE);
      EV_EI:    offset = ALIGN'(OFS_EI);
      EV_UINT:  offset = rint ? ALIGN'(OFS_UINT)
                              : ALIGN'(OFS_UINT) + ALIGN'({prio, 4'h0});
      default:  offset = ALIGN'(OFS_SYNC);
    endcase
    addr = {base_sel[AW-1:ALIGN], offset};
  end
endmodule

// File: rtl/heg_table_fetch.sv
module heg_table_fetch #(
  parameter int AW   = 32,
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CH_W-1:0] chan,
  input  logic [AW-1:0]   table_base,
  input  logic            rd_valid,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  output logic            complete
);
  localparam int PAD = AW - CH_W - 2;

  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      rd_addr <= '0;
    end else if (!pending && start) begin
      pending <= 1'b1;
      rd_addr <= table_base + {{PAD{1'b0}}, chan, 2'b00};
    end else if (pending && rd_valid) begin
      pending <= 1'b0;
    end
  end

  assign rd_req   = pending;
  assign complete = pending && rd_valid;

  a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  a_r9_req_drops: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> !rd_req);
endmodule

// File: rtl/heg_vector_gen.sv
module heg_vector_gen
  import heg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 4,
  parameter int ALIGN  = 9,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_valid,
  input  logic [2:0]        ack_kind,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic [CH_W-1:0]   ack_chan,
  input  logic              ebv,
  input  logic [AW-1:0]     reset_base,
  input  logic [AW-1:0]     exc_base,
  input  logic [AW-1:0]     table_base,
  input  logic [NUM_CH-1:0] table_sel,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_data,
  output logic [AW-1:0]     handler_addr,
  output logic              done,
  output logic              busy
);
  logic          accept, use_table, direct_go, fetch_complete;
  logic [AW-1:0] direct_addr;

  assign accept    = ack_valid && !busy;
  assign use_table = (ack_kind == EV_UINT) && table_sel[ack_chan];
  assign direct_go = accept && !use_table;

  heg_direct #(.AW(AW), .PRIO_W(PRIO_W), .ALIGN(ALIGN)) u_direct (
    .kind     (ack_kind),
    .prio     (ack_prio),
    .ebv      (ebv),
    .rst_base (reset_base),
    .exc_base (exc_base),
    .addr     (direct_addr)
  );

  heg_table_fetch #(.AW(AW), .CH_W(CH_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (accept && use_table),
    .chan       (ack_chan),
    .table_base (table_base),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .complete   (fetch_complete)
  );

  assign busy = rd_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      handler_addr <= '0;
    end else begin
      done <= direct_go || fetch_complete;
      if (direct_go)           handler_addr <= direct_addr;
      else if (fetch_complete) handler_addr <= {rd_data[AW-1:1], 1'b0};
    end
  end

  a_r7_direct_next: assert property (@(posedge clk) disable iff (rst)
    direct_go |=> done);
  a_r2_reset_no_read: assert property (@(posedge clk) disable iff (rst)
    (accept && ack_kind == EV_RESET) |=> !rd_req);
  a_r9_even_result: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> (done && !handler_addr[0] && !busy));
  a_r10_busy_no_done: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_valid) |=> !done);
  a_r8_table_start: assert property (@(posedge clk) disable iff (rst)
    (accept && use_table) |=> (rd_req && busy));
endmodule

// File: tb/heg_vector_gen_bench.sv
module heg_vector_gen_bench;
  logic        clk = 0, rst = 1;
  logic        ack_valid = 0, ebv = 0, rd_valid = 0;
  logic [2:0]  ack_kind = 0;
  logic [3:0]  ack_prio = 0;
  logic [4:0]  ack_chan = 0;
  logic [31:0] reset_base = 0, exc_base = 0, table_base = 0, rd_data = 0;
  logic [31:0] table_sel = 0;
  logic        rd_req, done, busy;
  logic [31:0] rd_addr, handler_addr;

  int checks = 0, failures = 0, cyc = 0;
  typedef struct { logic [31:0] addr; int due; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  heg_vector_gen u_heg_vector_gen (
    .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_kind(ack_kind),
    .ack_prio(ack_prio), .ack_chan(ack_chan), .ebv(ebv),
    .reset_base(reset_base), .exc_base(exc_base), .table_base(table_base),
    .table_sel(table_sel), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .handler_addr(handler_addr),
    .done(done), .busy(busy));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [2:0] k, logic [3:0] p, logic e);
    logic [31:0] b, ofs;
    b = (k == 3'd0) ? reset_base : (e ? exc_base : reset_base);
    case (k)
      3'd0: ofs = 32'h000;
      3'd2: ofs = 32'h030;
      3'd3: ofs = 32'h040;
      3'd4: ofs = b[0] ? 32'h100 : 32'h100 + 32'(p) * 32'h10;
      default: ofs = 32'h010;
    endcase
    return (b & 32'hFFFF_FE00) + ofs;
  endfunction

  task automatic direct_ack(logic [2:0] k, logic [3:0] p, logic [4:0] c,
                            logic e, string tag);
    item_t it;
    ack_valid = 1; ack_kind = k; ack_prio = p; ack_chan = c; ebv = e;
    it.addr = model(k, p, e); it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic table_ack(logic [3:0] p, logic [4:0] c, int lat,
                           logic [31:0] data);
    item_t it;
    logic [31:0] exp_ra;
    exp_ra = table_base + 32'(c) * 4;
    ack_valid = 1; ack_kind = 3'd4; ack_prio = p; ack_chan = c; ebv = 1;
    @(negedge clk);
    ack_valid = 0;
    check(rd_req && busy, "R8 request raised", {31'd0, rd_req}, 32'd1);
    check(rd_addr == exp_ra, "R8 read address", rd_addr, exp_ra);
    ack_valid = 1; ack_kind = 3'd1;
    @(negedge clk);
    ack_valid = 0;
    check(!done, "R10 ack while busy dropped", {31'd0, done}, 32'd0);
    check(rd_addr == exp_ra && rd_req, "R10 address unchanged", rd_addr, exp_ra);
    repeat (lat) @(negedge clk);
    check(rd_req && rd_addr == exp_ra, "R8 address held", rd_addr, exp_ra);
    rd_valid = 1; rd_data = data;
    it.addr = data & 32'hFFFF_FFFE; it.due = cyc + 1; it.tag = "R9 table result";
    q.push_back(it);
    @(negedge clk);
    rd_valid = 0;
    check(!busy && !rd_req, "R9 busy and request drop", {31'd0, busy}, 32'd0);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(0, "R7 unexpected done", handler_addr, 32'hx);
      end else begin
        item_t it;
        it = q.pop_front();
        check(handler_addr == it.addr, it.tag, handler_addr, it.addr);
        check(cyc == it.due, {it.tag, " timing R7"}, 32'(cyc), 32'(it.due));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    reset_base = 32'h8000_23FE;
    exc_base   = 32'h4000_11FC;
    table_base = 32'h2000_0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(!done && !busy && !rd_req, "R1 reset state",
          {29'd0, done, busy, rd_req}, 32'd0);

    direct_ack(3'd0, 4'd0, 5'd0, 1'b1, "R2 reset ebv=1");
    table_sel[3] = 1'b1;
    direct_ack(3'd0, 4'd5, 5'd3, 1'b0, "R2 reset on table channel");
    check(!rd_req && !busy, "R2 no table read", {31'd0, rd_req}, 32'd0);
    direct_ack(3'd1, 4'd0, 5'd0, 1'b0, "R3 sync ebv=0");
    direct_ack(3'd1, 4'd0, 5'd0, 1'b1, "R3 sync ebv=1");
    direct_ack(3'd2, 4'd0, 5'd0, 1'b1, "R4 FE exception");
    direct_ack(3'd3, 4'd0, 5'd0, 1'b0, "R4 EI exception");
    direct_ack(3'd6, 4'd0, 5'd0, 1'b1, "R4 code 6 as sync");
    direct_ack(3'd4, 4'd0, 5'd0, 1'b0, "R5 prio 0");
    direct_ack(3'd4, 4'd15, 5'd1, 1'b1, "R5 prio 15");
    direct_ack(3'd4, 4'd7, 5'd2, 1'b0, "R5 prio 7");
    @(negedge clk);
    exc_base = 32'h4000_11FD;
    direct_ack(3'd4, 4'd9, 5'd0, 1'b1, "R6 reduced offset");
    direct_ack(3'd4, 4'd12, 5'd0, 1'b1, "R6 reduced offset prio 12");
    exc_base = 32'h4000_11FC; reset_base = 32'h8000_23FF;
    direct_ack(3'd4, 4'd9, 5'd0, 1'b1, "R6 other flag ignored");
    reset_base = 32'h8000_23FE;
    @(negedge clk);

    table_ack(4'd2, 5'd3, 1, 32'h1234_5679);
    table_sel[31] = 1'b1;
    table_ack(4'd8, 5'd31, 5, 32'h0BAD_CAFE);
    direct_ack(3'd4, 4'd1, 5'd30, 1'b1, "R7 direct after table");

    rd_valid = 1; rd_data = 32'hFFFF_FFFF;
    @(negedge clk);
    rd_valid = 0;
    check(!done && !busy, "R10 stray read reply ignored", {31'd0, done}, 32'd0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R7 all results delivered", 32'(q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule